// File: doc/BRIEF.md
# Word-Parallel Self-Synchronizing PRBS Error Checker

This block sits on the receive side of a serial link that is carrying a pseudo-random bit sequence. It takes one data word per accepted clock cycle and finds bit errors without a stored copy of the expected pattern and without a local reference generator. The received bits feed the block's own history register. For each bit position, the block XORs the incoming bit with the earlier bits that sit at the polynomial's tap distances. On a clean stream this result is zero, so every one in the result marks a disturbance.

The ones in each checked word are counted and added to a saturating event total. Every isolated line error produces exactly three events, one for each term of the trinomial. Software divides the event total by three to get the number of bit errors. A second counter totals the received bits so that a rate can be formed. A lock flag reports that the stream has stayed clean for a while. Either of two sequences can be checked, a short one of degree 7 or a long one of degree 31, and the choice is made by a mode input.

Top module: `prbs_word_checker`

## Requirements
- R1: After reset or clear, the bit positions of the first D received bits (D = 7 in mode 0, 31 in mode 1) add nothing to the event total. Any correctly formed stream, whatever its starting phase, therefore leaves the total at zero.
- R2: Each error bit is the XOR of the received bit at time t with the received bits at t−A and t−B. The values are A=6, B=7 when poly_sel=0 (x^7+x^6+1) and A=28, B=31 when poly_sel=1 (x^31+x^28+1). An isolated flipped bit adds exactly 3 to err_events, even when those 3 ones fall in different words.
- R3: Each accepted word is checked in one cycle, with data_in[0] as the earliest bit in time. bits_seen increases by W on every accepted word.
- R4: poly_sel picks the polynomial. It may only be changed together with a clear.
- R5: On a cycle with valid_in low, err_events, bits_seen, locked and the history all hold.
- R6: err_events saturates at its all-ones value instead of wrapping.
- R7: A synchronous clear zeroes both counters, the lock flag and the clean-word run, and restarts priming. When clear and valid_in are high in the same cycle, clear wins and the word is dropped.
- R8: locked rises on the clock edge that accepts the LOCK_WORDS-th consecutive word with zero counted errors. It falls on any accepted word whose error count exceeds ERR_THRESH. A count from 1 to ERR_THRESH leaves locked unchanged but restarts the run.
- R9: The asynchronous active-low reset gives err_events=0, bits_seen=0 and locked=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of counters, lock and priming |
| poly_sel | input | 1 | 0: x^7+x^6+1, 1: x^31+x^28+1 |
| valid_in | input | 1 | data_in carries a word this cycle |
| data_in | input | W | Received word, bit 0 earliest |
| err_events | output | ACC_W | Saturating total of checker ones (three per bit error) |
| bits_seen | output | BITS_W | Total received bits |
| locked | output | 1 | Stream judged clean |

## Verification
A clear and a valid word can arrive in the same cycle, and so can a lock loss and an accumulator update. The bench provokes the first by raising clear together with valid_in while the word holds injected flips. It then expects zeroed counters and a fresh priming window, with no trace of the dropped word. The second comes from a word whose count exceeds the threshold: the bench checks in the same sampled cycle that the event total grew by that count and that locked fell.

// File: rtl/prbs_word_checker.sv
module prbs_word_checker #(
  parameter int W          = 32,
  parameter int ACC_W      = 32,
  parameter int BITS_W     = 48,
  parameter int LOCK_WORDS = 16,
  parameter int ERR_THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              poly_sel,
  input  logic              valid_in,
  input  logic [W-1:0]      data_in,
  output logic [ACC_W-1:0]  err_events,
  output logic [BITS_W-1:0] bits_seen,
  output logic              locked
);
  localparam int HW    = 31;
  localparam int CNT_W = $clog2(W + 1);
  localparam int LK_W  = $clog2(LOCK_WORDS + 1);

  logic [HW-1:0]    hist;
  logic [W+HW-1:0]  ext;
  logic [5:0]       primed, primed_nxt, deg;
  logic [W-1:0]     err_vec;
  logic [CNT_W-1:0] pop;
  logic [ACC_W:0]   acc_sum;
  logic [LK_W-1:0]  run;
  logic             take;

  assign take = valid_in && !clear;
  assign ext  = {data_in, hist};
  assign deg  = poly_sel ? 6'd31 : 6'd7;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic t_short, t_long, live;
    assign t_short = ext[HW+i] ^ ext[HW+i-6]  ^ ext[HW+i-7];
    assign t_long  = ext[HW+i] ^ ext[HW+i-28] ^ ext[HW+i-31];
    assign live    = (32'(primed) + 32'(i)) >= 32'(deg);
    assign err_vec[i] = (poly_sel ? t_long : t_short) & live;
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) pop = pop + CNT_W'(err_vec[i]);
  end

  assign acc_sum    = {1'b0, err_events} + (ACC_W+1)'(pop);
  assign primed_nxt = (32'(primed) + 32'(W) >= 32'(HW)) ? 6'(HW) : 6'(32'(primed) + 32'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist       <= '0;
      primed     <= '0;
      err_events <= '0;
      bits_seen  <= '0;
      run        <= '0;
      locked     <= 1'b0;
    end else if (clear) begin
      primed     <= '0;
      err_events <= '0;
      bits_seen  <= '0;
      run        <= '0;
      locked     <= 1'b0;
    end else if (take) begin
      hist       <= ext[W +: HW];
      primed     <= primed_nxt;
      bits_seen  <= bits_seen + BITS_W'(W);
      err_events <= acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
      if (pop == '0) begin
        if (run != LK_W'(LOCK_WORDS)) run <= run + 1'b1;
        if (32'(run) + 1 >= LOCK_WORDS) locked <= 1'b1;
      end else begin
        run <= '0;
        if (32'(pop) > ERR_THRESH) locked <= 1'b0;
      end
    end
  end
endmodule

module prbs_word_checker_chk #(
  parameter int W      = 32,
  parameter int ACC_W  = 32,
  parameter int BITS_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              valid_in,
  input logic [ACC_W-1:0]  err_events,
  input logic [BITS_W-1:0] bits_seen,
  input logic              locked
);
  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (err_events == '0 && bits_seen == '0 && !locked));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_in && !clear) |=> ($stable(err_events) && $stable(bits_seen) && $stable(locked)));

  // R3
  bits_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !clear) |=> bits_seen == $past(bits_seen) + BITS_W'(W));

  // R6
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> err_events >= $past(err_events));

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(valid_in) && !$past(clear)));
endmodule

bind prbs_word_checker prbs_word_checker_chk #(.W(W), .ACC_W(ACC_W), .BITS_W(BITS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear(clear), .valid_in(valid_in),
  .err_events(err_events), .bits_seen(bits_seen), .locked(locked)
);

// File: tb/prbs_word_checker_tb_top.sv
module prbs_word_checker_tb_top;
  localparam int W = 32, ACC_W = 8, BITS_W = 32, LOCKW = 4, THR = 2;
  localparam int ACC_MAX = (1 << ACC_W) - 1;

  logic clk = 0, rst_n = 0, clear = 0, poly_sel = 0, valid_in = 0;
  logic [W-1:0] data_in = '0;
  logic [ACC_W-1:0] err_events;
  logic [BITS_W-1:0] bits_seen;
  logic locked;

  prbs_word_checker #(.W(W), .ACC_W(ACC_W), .BITS_W(BITS_W), .LOCK_WORDS(LOCKW), .ERR_THRESH(THR)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .poly_sel(poly_sel), .valid_in(valid_in),
    .data_in(data_in), .err_events(err_events), .bits_seen(bits_seen), .locked(locked));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;
  logic [ACC_W+BITS_W:0] q_exp[$];
  string q_tag[$];

  // bench model
  bit mode = 0;
  logic [30:0] gen_h = '1;
  logic [63:0] fh = '0;
  int g = 0, m_acc = 0, m_run = 0;
  logic [BITS_W-1:0] m_bits = '0;
  bit m_lock = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit c, logic [W-1:0] flips, string tag);
    logic [W-1:0] d = '0;
    int a = mode ? 28 : 6, b = mode ? 31 : 7, pop = 0;
    @(negedge clk);
    if (c) begin
      m_acc = 0; m_bits = '0; m_lock = 0; m_run = 0; g = 0;
    end else if (v) begin
      for (int i = 0; i < W; i++) begin
        logic pb, e;
        pb = gen_h[a-1] ^ gen_h[b-1];
        gen_h = {gen_h[29:0], pb};
        d[i] = pb ^ flips[i];
        e = flips[i] ^ fh[a-1] ^ fh[b-1];
        fh = {fh[62:0], flips[i]};
        if (g >= b && e) pop++;
        g++;
      end
      m_acc = (m_acc + pop > ACC_MAX) ? ACC_MAX : m_acc + pop;
      m_bits = m_bits + BITS_W'(W);
      if (pop == 0) begin
        if (m_run + 1 >= LOCKW) m_lock = 1;
        if (m_run < LOCKW) m_run++;
      end else begin
        m_run = 0;
        if (pop > THR) m_lock = 0;
      end
    end
    valid_in = v; clear = c; poly_sel = mode;
    data_in = v ? (c ? ~flips : d) : '0;
    q_exp.push_back({ACC_W'(m_acc), m_bits, m_lock});
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on && q_exp.size() > 0) begin
      logic [ACC_W+BITS_W:0] ex;
      string t;
      ex = q_exp.pop_front();
      t = q_tag.pop_front();
      check({t, " R2 R6 err_events"}, err_events, ex[ACC_W+BITS_W:BITS_W+1]);
      check({t, " R3 bits_seen"}, bits_seen, ex[BITS_W:1]);
      check({t, " R8 locked"}, locked, ex[0]);
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    check("R9 reset err_events", err_events, 0);
    check("R9 reset bits_seen", bits_seen, 0);
    check("R9 reset locked", locked, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    // R1 R4: short polynomial, arbitrary phase, lock after 4 clean words
    for (int k = 0; k < 6; k++) step(1, 0, '0, "R1 R4 clean7");
    step(1, 0, 32'h0000_0400, "R2 single7");          // 3 in one word, unlock
    for (int k = 0; k < 5; k++) step(1, 0, '0, "R8 relock");
    step(1, 0, 32'h4000_0000, "R8 small count");      // 1 then 2: lock kept
    step(1, 0, '0, "R8 small count next");
    // R5: idle gaps hold everything
    step(0, 0, '0, "R5 idle");
    step(0, 0, 32'hFFFF_FFFF, "R5 idle junk");
    step(1, 0, 32'h8000_0000, "R2 boundary7");
    step(1, 0, '0, "R2 boundary7 next");
    for (int k = 0; k < 5; k++) step(1, 0, '0, "R8 relock2");
    // R7: clear with valid in the same cycle drops the word
    step(1, 1, 32'h0F0F_0F0F, "R7 clear+valid");
    step(1, 0, '0, "R7 R1 after clear");
    step(1, 0, '0, "R7 R1 after clear");
    // R4: long polynomial selected with clear
    mode = 1;
    step(0, 1, '0, "R4 R7 switch31");
    for (int k = 0; k < 5; k++) step(1, 0, '0, "R1 R4 clean31");
    step(1, 0, 32'h0000_0001, "R2 single31 same word");
    for (int k = 0; k < 5; k++) step(1, 0, '0, "R8 relock31");
    step(1, 0, 32'h0010_0000, "R2 single31 split");
    step(1, 0, '0, "R2 single31 split next");
    step(1, 0, '0, "R2 single31 tail");
    step(0, 1, '0, "R7 clear");
    step(1, 0, 32'h0000_0008, "R1 priming flip");
    step(1, 0, '0, "R1 priming flip next");
    step(1, 0, '0, "R1 priming flip tail");
    // R6: saturation on short polynomial
    mode = 0;
    step(0, 1, '0, "R6 R7 clear");
    for (int k = 0; k < 90; k++) step(1, 0, 32'h0000_0400, "R6 saturate");
    step(1, 0, '0, "R6 hold max");
    step(0, 0, '0, "R6 drain");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule